// File: doc/BRIEF.md
# Programmable Watchdog with Interrupt/Reset Steering

This block watches for a host that stops servicing it. It counts down a timeout measured in periods of an external tick strobe, nominally one sixteenth of a second. A single control byte sets the timeout. A 5-bit multiplier is scaled by a power of four chosen by a 2-bit resolution code. A steering bit in the same byte selects what happens at expiry.

At expiry a sticky flag is raised. The block then either pulses an interrupt, or pulses a reset request and wipes its own control byte. Writing the control byte, reading the kick location, or strobing the kick input all reload the count and clear the flag. After it expires the watchdog stays idle until it is reloaded. A multiplier of zero disarms it.

The host reaches the block through a byte-wide register port with separate write and read enables. Read data is registered and appears one cycle after the read strobe.

Top module: `wdog_steer`

## Requirements
- R1: While reset is held (sampled synchronously, active low), and after it is released, `irq_o`, `rst_req_o` and `flag_o` are 0, `rdata_o` is 0x00, and the control and flags registers read 0x00.
- R2: After a reload with control byte C, expiry happens on exactly the N-th tick strobe, where N = C[6:2] × 4^C[1:0]. The resulting pulse is visible in the cycle after the clock edge that samples that tick, and none appears on the first N−1 ticks.
- R3: The control register is at address 0x1FF7 and holds resolution in bits [1:0], multiplier in bits [6:2] and steering in bit 7. A read there returns the stored byte in the cycle after `rd_en_i`.
- R4: Writing the control register restarts the count with the newly written byte and clears the expiry flag.
- R5: On expiry, bit 7 of the flags register at 0x1FF0 is set, and so is `flag_o`. The flag stays set until the next reload. The other flag bits read 0.
- R6: With steering 0, expiry pulses `irq_o` high for exactly one cycle and leaves the control byte unchanged.
- R7: With steering 1, expiry pulses `rst_req_o` high for exactly one cycle and never `irq_o`. It clears the control register to 0x00 and clears bit 6 of the auxiliary register at 0x1FFC. That register stores only bit 6 of a write and reads 0 in every other bit.
- R8: A read of the kick location (0x1FF7) or a high `kick_i` reloads the count from the current control byte and clears the flag.
- R9: Writes to the flags register have no effect on the flag.
- R10: A multiplier of 0 disarms the watchdog: no expiry for any number of ticks.
- R11: After expiry no further expiry occurs until a reload.
- R12: A reload in the same cycle as the final tick wins: no expiry, and the count restarts from the full timeout.
- R13: A read of any address other than 0x1FF7, 0x1FF0 or 0x1FFC returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe (1/16 s) |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 13 | Register address |
| wdata_i | input | 8 | Write data |
| kick_i | input | 1 | Reload strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry (steering 0) |
| rst_req_o | output | 1 | One-cycle reset request on expiry (steering 1) |
| flag_o | output | 1 | Expiry flag |

## Verification
Directed timeouts cover the smallest, a mid-range and the largest (1984 ticks) encodings. They separate a correct power-of-four scaling from off-by-one or wrong-shift counting, and the early-tick counts show that no pulse arrives before the N-th tick.

Each steering value is driven to expiry, and the control and auxiliary registers are read back to tell the interrupt path from the reset path. Kicks by strobe, by kick-location read and on the final tick show that a reload restarts the count rather than only masking the pulse. A zero multiplier shows the watchdog is disarmed.

A seeded random mix of short timeouts, kicks, flag writes and reads then checks every cycle against a bench model. This exposes priority errors between reload, expiry and register writes.

// File: rtl/wdog_steer_pkg.sv
`timescale 1ns/1ps
// Shared field widths and the control byte layout for the watchdog.
// Assumes an 8-bit control byte: resolution, multiplier, steering bit.
package wdog_steer_pkg;
    localparam int RES_W  = 2;
    localparam int MULT_W = 5;
    localparam int NRES   = 1 << RES_W;
    // Largest timeout: multiplier shifted by 2*(NRES-1) bits
    localparam int CNT_W  = MULT_W + 2 * (NRES - 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_ctrl_t;
endpackage

// File: rtl/wdog_steer_decode.sv
`timescale 1ns/1ps
// Converts multiplier and resolution code into a timeout in ticks.
// Timeout = mult * 4^res. A zero multiplier yields zero (disarmed).
module wdog_steer_decode
    import wdog_steer_pkg::*;
(
    input  logic [MULT_W-1:0] mult_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [CNT_W-1:0]  ticks_o
);
    logic [CNT_W-1:0] scaled [NRES];

    // One shifted copy of the multiplier per resolution code
    generate
        for (genvar g = 0; g < NRES; g++) begin : g_scale
            assign scaled[g] = CNT_W'(mult_i) << (2 * g);
        end
    endgenerate

    assign ticks_o = scaled[res_i];
endmodule

// File: rtl/wdog_steer_counter.sv
`timescale 1ns/1ps
// Down-counter in tick units. A reload loads the timeout; each tick
// decrements a non-zero count; reaching zero on a tick signals expiry.
// Assumes reload has priority over a coincident tick. Zero means idle.
module wdog_steer_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Expiry on the tick that takes the count from one to zero
    assign expire_o = tick_i && !reload_i && (cnt_q == CNT_W'(1));

    // Count register: reload, else tick-decrement while armed
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload_i)
            cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    p_reload_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == $past(load_val_i)));
    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    p_idle_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && cnt_q == '0) |=> (cnt_q == '0));
    p_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && load_val_i == '0) |=> !expire_o);
endmodule

// File: rtl/wdog_steer_regs.sv
`timescale 1ns/1ps
// Register front end: control byte, read-only expiry flag, auxiliary
// bit, read mux, reload decode and the steered expiry pulses.
// Assumes expire_i is never high in a cycle that reloads.
module wdog_steer_regs
    import wdog_steer_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h1FF7),
    parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'('h1FF0),
    parameter logic [ADDR_W-1:0] AUX_ADDR  = ADDR_W'('h1FFC),
    parameter logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'('h1FF7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              kick_i,
    input  logic              expire_i,
    output logic              reload_o,
    output wd_ctrl_t          load_ctrl_o,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              flag_o
);
    wd_ctrl_t   ctrl_q;
    logic       flag_q, aux_q, irq_q, rst_q;
    logic [7:0] rdata_q;
    logic       wr_ctrl, wr_aux, rd_kick;

    // Address decode of the accesses that matter
    always_comb begin
        wr_ctrl = wr_en_i && (addr_i == CTRL_ADDR);
        wr_aux  = wr_en_i && (addr_i == AUX_ADDR);
        rd_kick = rd_en_i && (addr_i == KICK_ADDR);
    end

    assign reload_o    = wr_ctrl || rd_kick || kick_i;
    assign load_ctrl_o = wr_ctrl ? wd_ctrl_t'(wdata_i) : ctrl_q;

    // Control byte: host write, or wiped by a reset-steered expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wd_ctrl_t'(wdata_i);
        else if (expire_i && ctrl_q.steer)
            ctrl_q <= '0;
    end

    // Expiry flag: cleared by any reload, set by expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (reload_o)
            flag_q <= 1'b0;
        else if (expire_i)
            flag_q <= 1'b1;
    end

    // Auxiliary bit: expiry clear has priority over a host write
    always_ff @(posedge clk) begin
        if (!rst_n)
            aux_q <= 1'b0;
        else if (expire_i && ctrl_q.steer)
            aux_q <= 1'b0;
        else if (wr_aux)
            aux_q <= wdata_i[6];
    end

    // Steered one-cycle expiry pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            irq_q <= expire_i && !ctrl_q.steer;
            rst_q <= expire_i && ctrl_q.steer;
        end
    end

    // Registered read mux; unmapped addresses return all ones
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en_i) begin
            if (addr_i == CTRL_ADDR)
                rdata_q <= ctrl_q;
            else if (addr_i == FLAG_ADDR)
                rdata_q <= {flag_q, 7'b0};
            else if (addr_i == AUX_ADDR)
                rdata_q <= {1'b0, aux_q, 6'b0};
            else
                rdata_q <= 8'hFF;
        end
    end

    assign rdata_o   = rdata_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rst_q;
    assign flag_o    = flag_q;

    p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    p_rst_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);
    p_rst_wipes_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (ctrl_q == '0 && !aux_q));
    p_pulse_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && rst_q));
    p_flag_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);
    p_reload_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> !flag_q);
    p_flag_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == FLAG_ADDR && !reload_o && !expire_i) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/wdog_steer.sv
`timescale 1ns/1ps
// Programmable watchdog top: register front end, timeout decode and
// tick counter. Assumes tick_i is a one-cycle strobe in the clk domain.
module wdog_steer
    import wdog_steer_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h1FF7),
    parameter logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'('h1FF0),
    parameter logic [ADDR_W-1:0] AUX_ADDR  = ADDR_W'('h1FFC),
    parameter logic [ADDR_W-1:0] KICK_ADDR = ADDR_W'('h1FF7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              kick_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              flag_o
);
    logic             reload, expire;
    wd_ctrl_t         load_ctrl;
    logic [CNT_W-1:0] load_ticks;

    wdog_steer_regs #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FLAG_ADDR(FLAG_ADDR),
        .AUX_ADDR(AUX_ADDR), .KICK_ADDR(KICK_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .kick_i(kick_i),
        .expire_i(expire), .reload_o(reload), .load_ctrl_o(load_ctrl),
        .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .flag_o(flag_o)
    );

    wdog_steer_decode u_decode (
        .mult_i(load_ctrl.mult), .res_i(load_ctrl.res), .ticks_o(load_ticks)
    );

    wdog_steer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(reload),
        .load_val_i(load_ticks), .expire_o(expire)
    );
endmodule

// File: tb/wdog_steer_tb.sv
`timescale 1ns/1ps
module wdog_steer_tb_top;
    localparam logic [12:0] A_CTRL = 13'h1FF7;
    localparam logic [12:0] A_FLAG = 13'h1FF0;
    localparam logic [12:0] A_AUX  = 13'h1FFC;
    localparam logic [12:0] A_KICK = 13'h1FF7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0, kick_i = 1'b0;
    logic [12:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        irq_o, rst_req_o, flag_o;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [7:0]  m_ctrl;
    int          m_cnt;
    logic        m_flag, m_aux, e_irq, e_rst;
    logic [7:0]  e_rdata;

    always #10 clk = ~clk;

    wdog_steer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .kick_i(kick_i),
        .rdata_o(rdata_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .flag_o(flag_o)
    );

    function automatic int ticks_for(input logic [7:0] c);
        return int'(c[6:2]) * (1 << (2 * int'(c[1:0])));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus; called at a falling edge
    task automatic cyc(input bit t, input bit w, input bit r,
                       input logic [12:0] a, input logic [7:0] d, input bit k);
        bit reload, exp_now;
        tick_i = t; wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = d; kick_i = k;
        reload  = (w && a == A_CTRL) || (r && a == A_KICK) || k;
        exp_now = t && !reload && (m_cnt == 1);
        if (r) begin
            if (a == A_CTRL)      e_rdata = m_ctrl;
            else if (a == A_FLAG) e_rdata = {m_flag, 7'b0};
            else if (a == A_AUX)  e_rdata = {1'b0, m_aux, 6'b0};
            else                  e_rdata = 8'hFF;
        end
        e_irq = 1'b0; e_rst = 1'b0;
        if (reload) begin
            m_cnt  = ticks_for((w && a == A_CTRL) ? d : m_ctrl);
            m_flag = 1'b0;
        end else if (t && m_cnt != 0) m_cnt = m_cnt - 1;
        if (w && a == A_CTRL) m_ctrl = d;
        if (w && a == A_AUX)  m_aux = d[6];
        if (exp_now) begin
            m_flag = 1'b1;
            if (m_ctrl[7]) begin m_ctrl = 8'h00; m_aux = 1'b0; e_rst = 1'b1; end
            else e_irq = 1'b1;
        end
        @(negedge clk);
        tick_i = 0; wr_en_i = 0; rd_en_i = 0; kick_i = 0;
        check("R6 irq", int'(irq_o), int'(e_irq));
        check("R7 rst_req", int'(rst_req_o), int'(e_rst));
        check("R5 flag", int'(flag_o), int'(m_flag));
        if (r) check("R3 rdata", int'(rdata_o), int'(e_rdata));
    endtask

    task automatic idle();
        cyc(0, 0, 0, 13'h0, 8'h0, 0);
    endtask
    task automatic tick1();
        cyc(1, 0, 0, 13'h0, 8'h0, 0);
    endtask
    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        cyc(0, 1, 0, a, d, 0);
    endtask
    task automatic rd(input logic [12:0] a, output logic [7:0] v);
        cyc(0, 0, 1, a, 8'h0, 0);
        v = rdata_o;
    endtask
    // n ticks; counts cycles on which any expiry pulse was seen
    task automatic tick_n(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            tick1();
            if (irq_o || rst_req_o) seen++;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int seen;
        void'($urandom(32'd20240611));
        m_ctrl = 0; m_cnt = 0; m_flag = 0; m_aux = 0; e_irq = 0; e_rst = 0; e_rdata = 0;
        repeat (3) @(negedge clk);
        // R1: reset state while reset held
        check("R1 irq", int'(irq_o), 0);
        check("R1 rst_req", int'(rst_req_o), 0);
        check("R1 flag", int'(flag_o), 0);
        check("R1 rdata", int'(rdata_o), 0);
        rst_n = 1'b1;
        rd(A_FLAG, v); check("R1 flags reg", int'(v), 0);
        rd(A_CTRL, v); check("R1 ctrl reg", int'(v), 0);

        // R3/R2: res 1, mult 3 -> 12 ticks, interrupt steering
        wr(A_CTRL, 8'h0D);
        rd(A_CTRL, v); check("R3 ctrl readback", int'(v), 8'h0D);
        tick_n(11, seen); check("R2 no early expiry", seen, 0);
        tick1(); check("R2 expiry on 12th tick", int'(irq_o), 1);
        check("R6 no reset request", int'(rst_req_o), 0);
        idle(); check("R6 irq one cycle", int'(irq_o), 0);
        rd(A_FLAG, v); check("R5 flags bit7", int'(v), 8'h80);
        tick_n(20, seen); check("R11 one-shot", seen, 0);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, v); check("R9 flag write ignored (set)", int'(v), 8'h80);
        rd(A_CTRL, v); check("R6 ctrl retained", int'(v), 8'h0D);

        // R4: control write clears flag and restarts
        tick_n(12, seen);
        check("R4 flag before write", int'(flag_o), 1);
        wr(A_CTRL, 8'h0D);
        check("R4 flag cleared", int'(flag_o), 0);
        rd(A_FLAG, v); check("R4 flags reg cleared", int'(v), 0);
        wr(A_FLAG, 8'hFF);
        rd(A_FLAG, v); check("R9 flag write ignored (clear)", int'(v), 0);

        // R8: kick strobe reloads (timeout 4)
        wr(A_CTRL, 8'h10);
        tick_n(3, seen);
        cyc(0, 0, 0, 13'h0, 8'h0, 1);
        tick_n(3, seen); check("R8 kick strobe delays expiry", seen, 0);
        tick1(); check("R8 expiry after kick", int'(irq_o), 1);
        // R8: read of kick location reloads
        wr(A_CTRL, 8'h10);
        tick_n(3, seen);
        rd(A_KICK, v);
        tick_n(3, seen); check("R8 kick read delays expiry", seen, 0);
        tick1(); check("R8 expiry after kick read", int'(irq_o), 1);

        // R7: reset steering, timeout 2
        wr(A_AUX, 8'hFF);
        rd(A_AUX, v); check("R7 aux holds only bit6", int'(v), 8'h40);
        wr(A_CTRL, 8'h88);
        tick1(); check("R7 no early expiry", int'(rst_req_o), 0);
        tick1();
        check("R7 reset request", int'(rst_req_o), 1);
        check("R7 no interrupt", int'(irq_o), 0);
        check("R7 flag set", int'(flag_o), 1);
        idle(); check("R7 reset request one cycle", int'(rst_req_o), 0);
        rd(A_AUX, v); check("R7 aux bit6 cleared", int'(v), 0);
        rd(A_CTRL, v); check("R7 ctrl cleared", int'(v), 0);
        tick_n(10, seen); check("R7 stays idle", seen, 0);

        // R10: zero multiplier disarms
        wr(A_CTRL, 8'h03);
        tick_n(300, seen); check("R10 disarmed (irq steer)", seen, 0);
        wr(A_CTRL, 8'h83);
        tick_n(300, seen); check("R10 disarmed (reset steer)", seen, 0);

        // R12: reload on the final tick wins (timeout 2)
        wr(A_CTRL, 8'h08);
        tick1();
        cyc(1, 0, 0, 13'h0, 8'h0, 1);
        check("R12 no expiry with coincident kick", int'(irq_o), 0);
        tick1(); check("R12 full restart", int'(irq_o), 0);
        tick1(); check("R12 expiry after restart", int'(irq_o), 1);

        // R13: unmapped reads
        rd(13'h0100, v); check("R13 unmapped read", int'(v), 8'hFF);
        rd(13'h1FF1, v); check("R13 unmapped near flags", int'(v), 8'hFF);

        // R2: largest encoding, 31 * 64 = 1984 ticks
        wr(A_CTRL, 8'h7F);
        tick_n(1983, seen); check("R2 max no early expiry", seen, 0);
        tick1(); check("R2 max expiry", int'(irq_o), 1);

        // Random mix against the bench model
        for (int i = 0; i < 5000; i++) begin
            int op;
            logic [7:0] c;
            op = int'($urandom % 16);
            c  = {1'($urandom), 5'($urandom % 8), 2'($urandom % 3)};
            case (op)
                0:       wr(A_CTRL, c);
                1:       cyc(0, 0, 0, 13'h0, 8'h0, 1);
                2:       rd(A_KICK, v);
                3:       wr(A_FLAG, 8'($urandom));
                4:       rd(A_FLAG, v);
                5:       wr(A_AUX, 8'($urandom));
                6:       rd(A_AUX, v);
                7:       rd(13'($urandom), v);
                8:       cyc(1, 0, 0, 13'h0, 8'h0, 1);
                default: tick1();
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule